// File: doc/BRIEF.md
# Address Write Protection Controller

This block sits between the serial command front end of a small word-addressed non-volatile memory and its programming timer. It decides whether each decoded command may go ahead: a single-word write, a whole-array write, or a change to the protect boundary. It holds four pieces of state. The write-enable latch gates every write. The protect-enable arm lasts for a single instruction. The protect boundary sets the lowest address that can no longer be written. The lock bit freezes the boundary for good.

The front end issues one `cmd_stb` pulse per instruction, at the moment select falls. With it come the decoded command code, the 6-bit address field and the level of the program-enable pin. When a write-type command is allowed, the block sends a one-cycle launch pulse to the programming timer. It then stays busy until the timer reports completion, and only then does it apply the new boundary, cleared or lock state. A combinational probe tells the front end whether a word write to a given address would be accepted right now.

Top module: `wrprot_ctrl`

## Requirements
- R1: After reset, the write-enable latch and the arm are clear, the boundary is all ones (63), the cleared flag is set, the lock is clear, and `busy` and `prog_start` are low.
- R2: Command codes on `cmd_op` are: 0 read, 1 write enable, 2 write disable, 3 word write, 4 write all, 5 protect enable, 6 protect clear, 7 protect write, 8 lock, 9 protect read, with any other code treated as a read. Write enable sets the latch and write disable clears it at the strobe, whatever the pin level. Reads and protect reads never launch programming and never change the latch or the boundary.
- R3: A word write launches only if the latch is set, `pe_pin` is high, and either the cleared flag is set or the address is below the boundary.
- R4: Write all launches only if the cleared flag is set, the latch is set and `pe_pin` is high.
- R5: Protect enable arms only if the latch is set and `pe_pin` is high. Every other accepted strobe drops the arm, so the arm covers the very next instruction only.
- R6: Protect clear launches only if armed, `pe_pin` is high and the lock is clear. On completion it sets the boundary to 63 and the cleared flag, and in that state address 63 is writable.
- R7: Protect write launches only if armed, `pe_pin` is high, the cleared flag is set and the lock is clear. On completion it loads the address as the boundary and drops the cleared flag.
- R8: Lock launches only if armed, `pe_pin` is high and the lock is clear. On completion it sets the lock, after which the boundary and the cleared flag never change.
- R9: A launch raises `prog_start` for one cycle, in the cycle after the strobe, with `prog_kind` equal to the command code and `prog_addr` equal to the address. `busy` stays high until `prog_done`. Strobes that arrive while busy are ignored entirely.
- R10: A boundary of 63 loaded by protect write protects address 63, because the cleared flag is kept separately from the boundary value.
- R11: `probe_ok` is high exactly when a word write to `probe_addr` would launch now, with no command in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | One-cycle strobe at the end of an instruction |
| cmd_op | input | 4 | Decoded command code |
| cmd_addr | input | 6 | Address field of the instruction |
| pe_pin | input | 1 | Program-enable pin level |
| prog_done | input | 1 | Programming timer finished |
| probe_addr | input | 6 | Address for the write-allowed query |
| probe_ok | output | 1 | A word write to `probe_addr` would be accepted |
| prog_start | output | 1 | One-cycle launch to the programming timer |
| prog_kind | output | 4 | Command code of the launched operation |
| prog_addr | output | 6 | Address of the launched operation |
| busy | output | 1 | Operation in flight |
| wen | output | 1 | Write-enable latch |
| armed | output | 1 | Protect-enable arm |
| boundary | output | 6 | Protect boundary |
| cleared | output | 1 | Protect register in cleared state |
| locked | output | 1 | Permanent lock |

## Verification
The bench targets the arm's one-instruction lifetime. It checks that a read between protect enable and protect write kills the arm, because a design that leaked the arm would let that protect write through. It writes a boundary of 63 after a clear and checks that address 63 is rejected. A design that compared against the boundary value alone would treat 63 as the cleared pattern and allow the write. It also checks that protect write is refused without a prior clear, that clear and write are refused once locked, and that a write disable sent while an operation is in flight leaves the latch unchanged.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [3:0] {
    OP_READ   = 4'd0,
    OP_WEN    = 4'd1,
    OP_WDS    = 4'd2,
    OP_WRITE  = 4'd3,
    OP_WRALL  = 4'd4,
    OP_PREN   = 4'd5,
    OP_PRCLR  = 4'd6,
    OP_PRWR   = 4'd7,
    OP_PRLOCK = 4'd8,
    OP_PRREAD = 4'd9
  } op_t;
endpackage

// File: rtl/wp_enable_latch.sv
module wp_enable_latch
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  op_t  op,
  input  logic pe,
  output logic wen_q,
  output logic armed_q
);
  logic wen_d, armed_d;

  always_comb begin
    wen_d   = wen_q;
    armed_d = armed_q;
    if (take) begin
      if (op == OP_WEN) wen_d = 1'b1;
      if (op == OP_WDS) wen_d = 1'b0;
      armed_d = (op == OP_PREN) && wen_q && pe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      wen_q   <= wen_d;
      armed_q <= armed_d;
    end
  end

  // R5: the arm never outlives a second instruction
  a_r5_arm_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && take && op != OP_PREN) |=> !armed_q);
  // R2: write disable always clears the latch
  a_r2_wds_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_WDS) |=> !wen_q);
endmodule

// File: rtl/wp_bound_reg.sv
module wp_bound_reg
  import wp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_t               kind,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] bound_q,
  output logic              clr_q,
  output logic              lock_q
);
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  logic [ADDR_W-1:0] bound_d;
  logic              clr_d, lock_d;
  logic              upd;

  assign upd = commit && !lock_q;

  always_comb begin
    bound_d = bound_q;
    clr_d   = clr_q;
    lock_d  = lock_q;
    if (upd) begin
      unique case (kind)
        OP_PRCLR:  begin bound_d = ALL_ONES; clr_d = 1'b1; end
        OP_PRWR:   begin bound_d = addr;     clr_d = 1'b0; end
        OP_PRLOCK: lock_d = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q <= ALL_ONES;
      clr_q   <= 1'b1;
      lock_q  <= 1'b0;
    end else if (upd) begin
      bound_q <= bound_d;
      clr_q   <= clr_d;
      lock_q  <= lock_d;
    end
  end

  // R8: once locked, the protect state is frozen
  a_r8_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(bound_q) && $stable(clr_q)));
endmodule

// File: rtl/wp_pend.sv
module wp_pend
  import wp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  op_t               kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              done,
  output logic              busy_q,
  output logic              start_q,
  output op_t               kind_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic busy_d;

  always_comb begin
    busy_d = busy_q;
    if (done)   busy_d = 1'b0;
    if (launch) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= launch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_READ;
      addr_q <= '0;
    end else if (launch) begin
      kind_q <= kind_in;
      addr_q <= addr_in;
    end
  end

  // R9: a launch is always accompanied by busy and lasts one cycle
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q);
  a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
endmodule

// File: rtl/wrprot_ctrl.sv
module wrprot_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pe_pin,
  input  logic              prog_done,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_ok,
  output logic              prog_start,
  output logic [OP_W-1:0]   prog_kind,
  output logic [ADDR_W-1:0] prog_addr,
  output logic              busy,
  output logic              wen,
  output logic              armed,
  output logic [ADDR_W-1:0] boundary,
  output logic              cleared,
  output logic              locked
);
  localparam int SYNC_N = 2;

  // asynchronous assertion, synchronous release
  logic [SYNC_N-1:0] rst_sync;
  logic              rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync[SYNC_N-1];

  op_t op;
  always_comb begin
    if (cmd_op <= OP_W'(OP_PRREAD)) op = op_t'(cmd_op);
    else                            op = OP_READ;
  end

  logic take, ok, launch, commit;
  op_t  pend_kind;

  function automatic logic addr_open(input logic [ADDR_W-1:0] a,
                                     input logic clr,
                                     input logic [ADDR_W-1:0] bnd);
    return clr || (a < bnd);
  endfunction

  assign take = cmd_stb && !busy;

  always_comb begin
    unique case (op)
      OP_WRITE:  ok = wen && pe_pin && addr_open(cmd_addr, cleared, boundary);
      OP_WRALL:  ok = cleared && wen && pe_pin;
      OP_PRCLR:  ok = armed && pe_pin && !locked;
      OP_PRWR:   ok = armed && pe_pin && cleared && !locked;
      OP_PRLOCK: ok = armed && pe_pin && !locked;
      default:   ok = 1'b0;
    endcase
  end

  assign launch   = take && ok;
  assign commit   = busy && prog_done;
  assign probe_ok = wen && pe_pin && addr_open(probe_addr, cleared, boundary);

  wp_enable_latch u_latch (
    .clk(clk), .rst_n(rst_i_n), .take(take), .op(op), .pe(pe_pin),
    .wen_q(wen), .armed_q(armed)
  );

  wp_bound_reg #(.ADDR_W(ADDR_W)) u_bound (
    .clk(clk), .rst_n(rst_i_n), .commit(commit), .kind(pend_kind),
    .addr(prog_addr), .bound_q(boundary), .clr_q(cleared), .lock_q(locked)
  );

  wp_pend #(.ADDR_W(ADDR_W)) u_pend (
    .clk(clk), .rst_n(rst_i_n), .launch(launch), .kind_in(op),
    .addr_in(cmd_addr), .done(prog_done), .busy_q(busy),
    .start_q(prog_start), .kind_q(pend_kind), .addr_q(prog_addr)
  );

  assign prog_kind = OP_W'(pend_kind);

  // R3: no word write launch without the latch
  a_r3_write_needs_wen: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_stb && !busy && op == OP_WRITE && !wen) |=> !prog_start);
  // R4: write all launches only from the cleared state
  a_r4_wrall_cleared: assert property (@(posedge clk) disable iff (!rst_i_n)
    (prog_start && pend_kind == OP_WRALL) |-> cleared);
  // R9: strobes while busy leave the latch untouched
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_stb && busy) |=> $stable(wen));
endmodule

// File: tb/wrprot_ctrl_test.sv
module wrprot_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_stb = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic [5:0] cmd_addr = 6'd0;
  logic       pe_pin = 1'b0;
  logic       prog_done = 1'b0;
  logic [5:0] probe_addr = 6'd0;
  logic       probe_ok, prog_start, busy, wen, armed, cleared, locked;
  logic [3:0] prog_kind;
  logic [5:0] prog_addr, boundary;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wrprot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .pe_pin(pe_pin), .prog_done(prog_done),
    .probe_addr(probe_addr), .probe_ok(probe_ok), .prog_start(prog_start),
    .prog_kind(prog_kind), .prog_addr(prog_addr), .busy(busy), .wen(wen),
    .armed(armed), .boundary(boundary), .cleared(cleared), .locked(locked)
  );

  localparam logic [3:0] RD = 4'd0, WE = 4'd1, WD = 4'd2, WR = 4'd3,
                         WA = 4'd4, PN = 4'd5, PC = 4'd6, PW = 4'd7,
                         PL = 4'd8, PR = 4'd9;
  localparam int NV = 37;
  // {op, addr, pe, start, wen, armed, boundary, cleared, locked}
  localparam logic [21:0] TBL [NV] = '{
    {WR, 6'd5,  1'b1, 1'b0, 1'b0, 1'b0, 6'd63, 1'b1, 1'b0}, // R3 no latch
    {PN, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 6'd63, 1'b1, 1'b0}, // R5 no latch
    {WE, 6'd0,  1'b0, 1'b0, 1'b1, 1'b0, 6'd63, 1'b1, 1'b0}, // R2 pe low ok
    {WR, 6'd63, 1'b0, 1'b0, 1'b1, 1'b0, 6'd63, 1'b1, 1'b0}, // R3 pe low
    {WR, 6'd63, 1'b1, 1'b1, 1'b1, 1'b0, 6'd63, 1'b1, 1'b0}, // R6 top open
    {WA, 6'd0,  1'b1, 1'b1, 1'b1, 1'b0, 6'd63, 1'b1, 1'b0}, // R4
    {PW, 6'd20, 1'b1, 1'b0, 1'b1, 1'b0, 6'd63, 1'b1, 1'b0}, // R7 unarmed
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd63, 1'b1, 1'b0}, // R5 arm
    {PW, 6'd20, 1'b1, 1'b1, 1'b1, 1'b0, 6'd20, 1'b0, 1'b0}, // R7
    {WR, 6'd19, 1'b1, 1'b1, 1'b1, 1'b0, 6'd20, 1'b0, 1'b0}, // R3 below
    {WR, 6'd20, 1'b1, 1'b0, 1'b1, 1'b0, 6'd20, 1'b0, 1'b0}, // R3 at bound
    {WA, 6'd0,  1'b1, 1'b0, 1'b1, 1'b0, 6'd20, 1'b0, 1'b0}, // R4 not clr
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd20, 1'b0, 1'b0}, // R5
    {RD, 6'd7,  1'b1, 1'b0, 1'b1, 1'b0, 6'd20, 1'b0, 1'b0}, // R5 drop
    {PC, 6'd63, 1'b1, 1'b0, 1'b1, 1'b0, 6'd20, 1'b0, 1'b0}, // R6 unarmed
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd20, 1'b0, 1'b0}, // R5
    {PW, 6'd10, 1'b1, 1'b0, 1'b1, 1'b0, 6'd20, 1'b0, 1'b0}, // R7 no clr
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd20, 1'b0, 1'b0}, // R5
    {PC, 6'd63, 1'b1, 1'b1, 1'b1, 1'b0, 6'd63, 1'b1, 1'b0}, // R6
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd63, 1'b1, 1'b0}, // R5
    {PW, 6'd63, 1'b1, 1'b1, 1'b1, 1'b0, 6'd63, 1'b0, 1'b0}, // R7
    {WR, 6'd63, 1'b1, 1'b0, 1'b1, 1'b0, 6'd63, 1'b0, 1'b0}, // R10
    {WR, 6'd62, 1'b1, 1'b1, 1'b1, 1'b0, 6'd63, 1'b0, 1'b0}, // R10
    {WD, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 6'd63, 1'b0, 1'b0}, // R2
    {PN, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 6'd63, 1'b0, 1'b0}, // R5
    {WE, 6'd0,  1'b1, 1'b0, 1'b1, 1'b0, 6'd63, 1'b0, 1'b0}, // R2
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd63, 1'b0, 1'b0}, // R5
    {PL, 6'd0,  1'b1, 1'b1, 1'b1, 1'b0, 6'd63, 1'b0, 1'b1}, // R8
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd63, 1'b0, 1'b1}, // R5
    {PC, 6'd63, 1'b1, 1'b0, 1'b1, 1'b0, 6'd63, 1'b0, 1'b1}, // R8 clr
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd63, 1'b0, 1'b1}, // R5
    {PW, 6'd5,  1'b1, 1'b0, 1'b1, 1'b0, 6'd63, 1'b0, 1'b1}, // R8 write
    {PN, 6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 6'd63, 1'b0, 1'b1}, // R5
    {PR, 6'd0,  1'b1, 1'b0, 1'b1, 1'b0, 6'd63, 1'b0, 1'b1}, // R2 prread
    {PN, 6'd0,  1'b0, 1'b0, 1'b1, 1'b0, 6'd63, 1'b0, 1'b1}, // R5 pe low
    {WR, 6'd1,  1'b0, 1'b0, 1'b1, 1'b0, 6'd63, 1'b0, 1'b1}, // R3 pe low
    {WR, 6'd1,  1'b1, 1'b1, 1'b1, 1'b0, 6'd63, 1'b0, 1'b1}  // R9 word write
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [5:0] a, input logic pe);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_op = op; cmd_addr = a; pe_pin = pe;
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    prog_done = 1'b1;
    @(negedge clk);
    prog_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_reset_state();
    chk("R1 wen", wen, 0);
    chk("R1 armed", armed, 0);
    chk("R1 boundary", boundary, 63);
    chk("R1 cleared", cleared, 1);
    chk("R1 locked", locked, 0);
    chk("R1 busy", busy, 0);
    chk("R1 prog_start", prog_start, 0);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk_reset_state();

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = TBL[i];
      send(v[21:18], v[17:12], v[11]);
      chk($sformatf("R9 start row %0d", i), prog_start, v[10]);
      if (v[10]) begin
        chk($sformatf("R9 kind row %0d", i), prog_kind, v[21:18]);
        chk($sformatf("R9 addr row %0d", i), prog_addr, v[17:12]);
        finish_op();
        chk($sformatf("R9 idle row %0d", i), busy, 0);
      end
      chk($sformatf("R2 wen row %0d", i), wen, v[9]);
      chk($sformatf("R5 armed row %0d", i), armed, v[8]);
      chk($sformatf("R7 boundary row %0d", i), boundary, v[7:2]);
      chk($sformatf("R6 cleared row %0d", i), cleared, v[1]);
      chk($sformatf("R8 locked row %0d", i), locked, v[0]);
    end

    // R11 probe: boundary 63, not cleared, latch set
    pe_pin = 1'b1; probe_addr = 6'd62;
    @(negedge clk);
    chk("R11 probe 62", probe_ok, 1);
    probe_addr = 6'd63;
    @(negedge clk);
    chk("R11 probe 63", probe_ok, 0);
    pe_pin = 1'b0; probe_addr = 6'd0;
    @(negedge clk);
    chk("R11 probe pe low", probe_ok, 0);

    // R9: strobes while busy are ignored
    send(WR, 6'd0, 1'b1);
    chk("R9 launch", prog_start, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", prog_start, 0);
    send(WD, 6'd0, 1'b1);
    chk("R9 busy held", busy, 1);
    chk("R9 wds ignored while busy", wen, 1);
    finish_op();
    chk("R9 busy cleared", busy, 0);
    chk("R9 latch kept", wen, 1);

    // R1: reset mid-run
    do_reset();
    chk_reset_state();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule